// File: doc/BRIEF.md
# Count-Min Frequency Sketch with Tree Minimum

The block estimates how often each sample value has been seen. It keeps a grid of saturating counters, `ROWS` rows deep and `COLS` buckets wide. Each row maps a sample to one bucket with its own hash of the form (multiplier × sample + offset) mod `COLS`. The multiplier and offset for each row are parameters.

An update command raises the addressed counter in every row by one. A query command reads the addressed counter from every row and reduces those values to their smallest through a balanced tree of two-input unsigned minimum stages. The tree depth is ceil(log2(`ROWS`)). The smallest value is an upper bound on the true count of that sample. It is returned in a registered 64-bit result together with a one-cycle ready pulse.

A row count that is not a power of two is padded up to the next power of two with all-ones leaves, and those leaves never win a comparison. A bucket count that is not a power of two is handled by a true modulo on the full-width hash sum.

Top module: `cms_sketch`

## Requirements
- R1: When `rst` is high at a clock edge, every counter becomes zero, `result` becomes zero and `rd_ready` goes low.
- R2: When `cmd` = 1 at a clock edge, each row increments exactly one counter, the one its hash selects for `sample`. A query in the following cycle already sees the new values.
- R3: Row r selects bucket (HASH_A[r] × sample + HASH_B[r]) mod COLS. The coefficient for row r sits in bits [r×COEF_W +: COEF_W] of its parameter. The sum is formed at full width before the modulo, so any COLS, including values that are not a power of two, gives a uniform range 0..COLS-1.
- R4: When `cmd` = 2 at a clock edge, `result` takes the unsigned minimum of the ROWS addressed counters, zero-extended to 64 bits. Bits 63..CNT_W are always zero.
- R5: `result` and `rd_ready` are registered. In the cycle after a query edge, the new `result` is present and `rd_ready` is 1. After any edge without a query, `rd_ready` is 0.
- R6: `result` holds its value across every edge that is not a query.
- R7: `cmd` values 0 and 3 to 7 change no counter and do not affect `result` or `rd_ready` beyond R5 and R6.
- R8: A counter at 2^CNT_W − 1 stays there on further updates instead of wrapping.
- R9: When ROWS is not a power of two, the padding leaves of the minimum tree hold all ones and never lower the result below the true minimum of the real rows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | Command: 1 update, 2 query, others no operation |
| sample | input | SAMPLE_W | Sample value to hash |
| result | output | 64 | Registered minimum count of the last query |
| rd_ready | output | 1 | One-cycle pulse: result holds a fresh query answer |

## Verification
The bench runs with three rows and thirteen buckets, so both the bucket modulo and the padded tree leaf are exercised. It updates a sweep of 64 samples with multiplicities from one to four. Samples share buckets in some rows but not others, so the per-row counts differ. Queries over 100 samples, including never-updated ones, then tell a correct per-row hash and a true minimum apart from a wrong coefficient, a wrong modulo, a max, or a stage that passes one fixed side. Further runs cover every no-operation code, 300 updates of one sample to reach saturation, and idle cycles that show the result holding and ready dropping.

// File: rtl/cms_pkg.sv
package cms_pkg;

    // Command codes seen on the cmd port
    typedef enum logic [2:0] {
        CMD_NOP    = 3'd0,
        CMD_UPDATE = 3'd1,
        CMD_QUERY  = 3'd2
    } cms_cmd_e;

    localparam int RESULT_W = 64;

    // Registered answer of the query path
    typedef struct packed {
        logic                ready;
        logic [RESULT_W-1:0] value;
    } cms_answer_t;

    // Number of leaves of a balanced binary tree holding n inputs
    function automatic int tree_leaves(input int n);
        int l;
        l = 1;
        while (l < n) l = l * 2;
        return l;
    endfunction

    // Number of comparator levels for n inputs
    function automatic int tree_levels(input int n);
        int l;
        int d;
        l = 1;
        d = 0;
        while (l < n) begin
            l = l * 2;
            d = d + 1;
        end
        return d;
    endfunction

endpackage

// File: rtl/cms_hash_row.sv
module cms_hash_row #(
    parameter int          SAMPLE_W = 16,
    parameter int          COEF_W   = 16,
    parameter int          COLS     = 13,
    parameter logic [COEF_W-1:0] MUL = '0,
    parameter logic [COEF_W-1:0] ADD = '0,
    localparam int         IDX_W    = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic [SAMPLE_W-1:0] sample,
    output logic [IDX_W-1:0]    idx
);

    localparam int SUM_W = SAMPLE_W + COEF_W + 1;

    logic [SUM_W-1:0] prod;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] rem;

    always_comb begin
        prod = SUM_W'(MUL) * SUM_W'(sample);
        sum  = prod + SUM_W'(ADD);
        rem  = sum % SUM_W'(COLS);
        idx  = IDX_W'(rem);
    end

endmodule

// File: rtl/cms_row_bank.sv
module cms_row_bank #(
    parameter int  COLS  = 13,
    parameter int  CNT_W = 8,
    localparam int IDX_W = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc_en,
    input  logic [IDX_W-1:0] idx,
    output logic [CNT_W-1:0] rd_val
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt [COLS];

    for (genvar c = 0; c < COLS; c++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst) begin
                cnt[c] <= '0;
            end else if (inc_en && (idx == IDX_W'(c)) && (cnt[c] != CNT_MAX)) begin
                cnt[c] <= cnt[c] + CNT_W'(1);
            end
        end
    end

    always_comb begin
        rd_val = '0;
        for (int c = 0; c < COLS; c++) begin
            if (idx == IDX_W'(c)) rd_val = cnt[c];
        end
    end

endmodule

// File: rtl/cms_min_tree.sv
module cms_min_tree
    import cms_pkg::*;
#(
    parameter int  N      = 3,
    parameter int  W      = 8,
    localparam int LEAVES = tree_leaves(N),
    localparam int LEVELS = tree_levels(N)
) (
    input  logic [N*W-1:0] leaves,
    output logic [W-1:0]   min_o
);

    for (genvar lv = 0; lv <= LEVELS; lv++) begin : g_lvl
        localparam int NODES = LEAVES >> lv;
        logic [W-1:0] node [NODES];

        if (lv == 0) begin : g_leaf
            for (genvar i = 0; i < NODES; i++) begin : g_in
                if (i < N) begin : g_real
                    assign node[i] = leaves[i*W +: W];
                end else begin : g_pad
                    assign node[i] = '1;
                end
            end
        end else begin : g_cmp
            for (genvar i = 0; i < NODES; i++) begin : g_pair
                logic [W-1:0] lhs;
                logic [W-1:0] rhs;
                assign lhs     = g_lvl[lv-1].node[2*i];
                assign rhs     = g_lvl[lv-1].node[2*i+1];
                // ties pass the right-hand operand
                assign node[i] = (lhs < rhs) ? lhs : rhs;
            end
        end
    end

    assign min_o = g_lvl[LEVELS].node[0];

endmodule

// File: rtl/cms_sketch.sv
module cms_sketch
    import cms_pkg::*;
#(
    parameter int  ROWS     = 3,
    parameter int  COLS     = 13,
    parameter int  CNT_W    = 8,
    parameter int  SAMPLE_W = 16,
    parameter int  COEF_W   = 16,
    parameter logic [ROWS*COEF_W-1:0] HASH_A = {16'd7, 16'd5, 16'd3},
    parameter logic [ROWS*COEF_W-1:0] HASH_B = {16'd9, 16'd4, 16'd1}
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [2:0]          cmd,
    input  logic [SAMPLE_W-1:0] sample,
    output logic [63:0]         result,
    output logic                rd_ready
);

    localparam int IDX_W = (COLS > 1) ? $clog2(COLS) : 1;

    logic              do_update;
    logic              do_query;
    logic [ROWS*CNT_W-1:0] row_vals;
    logic [CNT_W-1:0]  min_val;
    cms_answer_t       ans_q;

    assign do_update = (cmd == CMD_UPDATE);
    assign do_query  = (cmd == CMD_QUERY);

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] val;

        cms_hash_row #(
            .SAMPLE_W (SAMPLE_W),
            .COEF_W   (COEF_W),
            .COLS     (COLS),
            .MUL      (HASH_A[r*COEF_W +: COEF_W]),
            .ADD      (HASH_B[r*COEF_W +: COEF_W])
        ) u_hash (
            .sample (sample),
            .idx    (idx)
        );

        cms_row_bank #(
            .COLS  (COLS),
            .CNT_W (CNT_W)
        ) u_bank (
            .clk    (clk),
            .rst    (rst),
            .inc_en (do_update),
            .idx    (idx),
            .rd_val (val)
        );

        assign row_vals[r*CNT_W +: CNT_W] = val;
    end

    cms_min_tree #(
        .N (ROWS),
        .W (CNT_W)
    ) u_tree (
        .leaves (row_vals),
        .min_o  (min_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ans_q <= '0;
        end else begin
            ans_q.ready <= do_query;
            if (do_query) ans_q.value <= RESULT_W'(min_val);
        end
    end

    assign result   = ans_q.value;
    assign rd_ready = ans_q.ready;

endmodule

// File: rtl/cms_sketch_chk.sv
module cms_sketch_chk #(
    parameter int CNT_W = 8
) (
    input logic        clk,
    input logic        rst,
    input logic [2:0]  cmd,
    input logic [63:0] result,
    input logic        rd_ready
);

    // R5
    query_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == 3'd2) |=> rd_ready);

    // R5
    idle_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd != 3'd2) |=> !rd_ready);

    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd != 3'd2) |=> $stable(result));

    // R4
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_ready |-> (result >> CNT_W) == 64'd0);

endmodule

bind cms_sketch cms_sketch_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cmd      (cmd),
    .result   (result),
    .rd_ready (rd_ready)
);

// File: tb/cms_sketch_tb.sv
module cms_sketch_tb;

    localparam int ROWS  = 3;
    localparam int COLS  = 13;
    localparam int CNT_W = 8;
    localparam int SW    = 16;
    localparam int CMAX  = (1 << CNT_W) - 1;

    int mul_c [ROWS] = '{3, 5, 7};
    int add_c [ROWS] = '{1, 4, 9};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    cmd = 3'd0;
    logic [SW-1:0] sample = '0;
    logic [63:0]   result;
    logic          rd_ready;

    int model [ROWS][COLS];
    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    cms_sketch #(
        .ROWS     (ROWS),
        .COLS     (COLS),
        .CNT_W    (CNT_W),
        .SAMPLE_W (SW),
        .COEF_W   (16),
        .HASH_A   ({16'd7, 16'd5, 16'd3}),
        .HASH_B   ({16'd9, 16'd4, 16'd1})
    ) u_dut (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .sample   (sample),
        .result   (result),
        .rd_ready (rd_ready)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive away from the edge, return 1 time unit after it
    task automatic issue(input int c, input int s);
        cmd    = 3'(c);
        sample = SW'(s);
        @(posedge clk);
        #1;
    endtask

    function automatic int bucket(input int r, input int s);
        return (mul_c[r] * s + add_c[r]) % COLS;
    endfunction

    task automatic model_update(input int s);
        for (int r = 0; r < ROWS; r++) begin
            if (model[r][bucket(r, s)] < CMAX) model[r][bucket(r, s)]++;
        end
    endtask

    function automatic int model_min(input int s);
        int m;
        m = CMAX;
        for (int r = 0; r < ROWS; r++) begin
            if (model[r][bucket(r, s)] < m) m = model[r][bucket(r, s)];
        end
        return m;
    endfunction

    task automatic query_check(input string req, input int s);
        issue(2, s);
        check(req, result, model_min(s));
        check("R5 ready after query", rd_ready, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        longint held;
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) model[r][c] = 0;

        #1;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1 result after reset", result, 0);
        check("R1 ready after reset", rd_ready, 0);
        rst = 1'b0;
        issue(0, 0);
        query_check("R1 counters zero", 5);

        // R2 R3: update sweep with varied multiplicities
        for (int s = 0; s < 64; s++) begin
            for (int k = 0; k <= (s % 4); k++) begin
                issue(1, s);
                model_update(s);
            end
        end
        // R4 R9: query sweep, including never-updated samples
        for (int s = 0; s < 100; s++) begin
            query_check("R4 minimum of rows", s);
        end

        // R2: query right after update sees the new value
        issue(1, 77);
        model_update(77);
        query_check("R2 update visible next cycle", 77);

        // R6 R5: result holds, ready drops on idle edges
        held = result;
        for (int i = 0; i < 3; i++) begin
            issue(0, 11 + i);
            check("R6 result holds", result, held);
            check("R5 ready one cycle", rd_ready, 0);
        end

        // R7: all no-operation codes leave counters alone
        for (int c = 0; c < 8; c++) begin
            if (c == 1 || c == 2) continue;
            for (int s = 0; s < 20; s++) issue(c, s);
            check("R7 ignored code ready", rd_ready, 0);
        end
        for (int s = 0; s < 20; s++) query_check("R7 ignored code no change", s);

        // R8: saturation
        for (int i = 0; i < 300; i++) begin
            issue(1, 500);
            model_update(500);
        end
        query_check("R8 saturated count", 500);
        check("R8 saturated value", result, CMAX);
        for (int s = 0; s < 40; s++) query_check("R8 R9 sweep after saturation", s);

        // R1: reset clears counters again
        rst = 1'b1;
        issue(0, 0);
        check("R1 ready in reset", rd_ready, 0);
        check("R1 result in reset", result, 0);
        rst = 1'b0;
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) model[r][c] = 0;
        query_check("R1 cleared after reset", 500);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule